// File: doc/BRIEF.md
# Packed SIMD Signed Greater-Than Comparator

This block takes one 32-bit instruction word together with two 128-bit operand vectors and produces a lane mask. It first works out which of four compare forms the word encodes: vector register-register, vector against zero, scalar 64-bit register-register, or scalar 64-bit against zero. It then compares the operand lanes as signed two's-complement numbers. For every lane where the first operand is strictly larger, that lane of the result is all ones. Every other lane is all zeros, and this includes lanes that are equal.

The lane width and the active vector length are decoded from each instruction, so consecutive instructions may use different lane shapes. The block sits in an execute stage. The register indices it decodes are passed out so that the surrounding pipeline can perform operand reads and the write-back. The result, the indices and the strobes are all registered, which gives exactly one cycle of latency. The compare never produces or alters condition flags, and the block has no flag outputs.

Top module: `simd_sgt_cmp`

## Requirements
- R1: Each result lane is all ones when the first operand lane is signed-greater than the second lane, and all zeros when it is less or equal. The most negative and most positive lane values are compared as signed numbers.
- R2: In the vector forms, instruction bits [23:22] select the lane width: 00 gives 8-bit lanes, 01 gives 16-bit, 10 gives 32-bit and 11 gives 64-bit.
- R3: In the vector forms, bit 30 set means all 128 bits are compared. Bit 30 clear means only bits [63:0] are compared and mask bits [127:64] are zero.
- R4: A word matching mask 0xBF20FC00 with value 0x0E203400 is the vector register-register form. The second-source index is in bits [20:16], the first-source index in bits [9:5] and the destination index in bits [4:0].
- R5: A word matching mask 0xBF3FFC00 with value 0x0E208800 is the vector compare-against-zero form. Each lane of the first operand is compared with zero, the second operand has no effect on the result, and the reported second-source index is 0.
- R6: A word matching mask 0xFFE0FC00 with value 0x5EE03400 compares one 64-bit element taken from bits [63:0]. Mask bits [127:64] are zero.
- R7: A word matching mask 0xFFFFFC00 with value 0x5EE08800 compares bits [63:0] of the first operand with zero. Mask bits [127:64] are zero and the reported second-source index is 0.
- R8: A vector-form word that has bits [23:22] = 11 and bit 30 = 0 is reserved. It raises the illegal flag and does not raise result-valid.
- R9: A word that matches none of the four forms raises the illegal flag and does not raise result-valid.
- R10: Result-valid or the illegal flag rises exactly one cycle after a cycle in which the input strobe is high, and never both at once. When result-valid is low, the mask and all index outputs are zero.
- R11: With a valid result, the destination, first-source and second-source index outputs carry the fields decoded from the accepted word.
- R12: While reset is high, and in the cycle after it is released, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| insn_vld_i | input | 1 | Instruction word is present this cycle |
| opa_i | input | 128 | First operand vector |
| opb_i | input | 128 | Second operand vector |
| mask_o | output | 128 | Registered per-lane all-ones/all-zeros result |
| rd_o | output | 5 | Decoded destination register index |
| rn_o | output | 5 | Decoded first-source register index |
| rm_o | output | 5 | Decoded second-source register index (0 for zero forms) |
| res_vld_o | output | 1 | Result and indices are valid |
| illegal_o | output | 1 | Accepted word was reserved or unrecognised |

## Verification
Two mechanisms shape the same result at the same time: the per-lane signed compare at the width that was decoded, and the narrowing that clears the upper half. A lane sitting across bit 64 is the first thing to break if either one is wrong. Random words therefore mix every width with both values of bit 30 and with both scalar forms, and the lane values are biased toward the most negative value, the most positive value, zero, minus one and equal pairs. A lane-by-lane reference function in the bench judges each result. Directed cases then take each width to its extremes in both directions, hold the first operand fixed under two different second operands in the zero forms, and interleave reserved and unmatched words with legal words in consecutive cycles.

// File: rtl/simd_sgt_pkg.sv
package simd_sgt_pkg;

    localparam int INSN_W     = 32;
    localparam int DATA_W     = 128;
    localparam int HALF_W     = DATA_W / 2;
    localparam int IDX_W      = 5;
    localparam int MIN_LANE_W = 8;
    localparam int NUM_LW     = 4;
    localparam int NUM_FORMS  = 4;

    // fixed-bit masks and values of the four accepted encodings
    localparam logic [INSN_W-1:0] VREG_MASK = 32'hBF20_FC00;
    localparam logic [INSN_W-1:0] VREG_VAL  = 32'h0E20_3400;
    localparam logic [INSN_W-1:0] VZRO_MASK = 32'hBF3F_FC00;
    localparam logic [INSN_W-1:0] VZRO_VAL  = 32'h0E20_8800;
    localparam logic [INSN_W-1:0] SREG_MASK = 32'hFFE0_FC00;
    localparam logic [INSN_W-1:0] SREG_VAL  = 32'h5EE0_3400;
    localparam logic [INSN_W-1:0] SZRO_MASK = 32'hFFFF_FC00;
    localparam logic [INSN_W-1:0] SZRO_VAL  = 32'h5EE0_8800;

    // field positions
    localparam int FULL_BIT = 30;
    localparam int SIZE_LO  = 22;
    localparam int RM_LO    = 16;
    localparam int RN_LO    = 5;
    localparam int RD_LO    = 0;

    typedef enum logic [1:0] {
        LW_8  = 2'b00,
        LW_16 = 2'b01,
        LW_32 = 2'b10,
        LW_64 = 2'b11
    } lane_w_e;

    typedef enum logic [2:0] {
        FORM_NONE,
        FORM_VEC_REG,
        FORM_VEC_ZERO,
        FORM_SCL_REG,
        FORM_SCL_ZERO
    } form_e;

    typedef struct packed {
        logic              legal;
        form_e             form;
        lane_w_e           lw;
        logic              full;
        logic              use_zero;
        logic [IDX_W-1:0]  rd;
        logic [IDX_W-1:0]  rn;
        logic [IDX_W-1:0]  rm;
    } dec_op_t;

    typedef struct packed {
        logic              vld;
        logic              ill;
        logic [DATA_W-1:0] mask;
        logic [IDX_W-1:0]  rd;
        logic [IDX_W-1:0]  rn;
        logic [IDX_W-1:0]  rm;
    } res_t;

    function automatic logic pat_hit(input logic [INSN_W-1:0] w,
                                     input logic [INSN_W-1:0] m,
                                     input logic [INSN_W-1:0] v);
        return (w & m) == v;
    endfunction

    function automatic logic [DATA_W-1:0] narrow_half(input logic [DATA_W-1:0] x);
        return {{(DATA_W-HALF_W){1'b0}}, x[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/sgt_decode.sv
module sgt_decode
    import simd_sgt_pkg::*;
(
    input  logic [INSN_W-1:0]    insn_i,
    output dec_op_t              op_o,
    output logic [NUM_FORMS-1:0] hit_o
);

    logic hit_vreg, hit_vzro, hit_sreg, hit_szro;
    logic is_vec, reserved;
    logic [1:0] size_f;

    assign hit_vreg = pat_hit(insn_i, VREG_MASK, VREG_VAL);
    assign hit_vzro = pat_hit(insn_i, VZRO_MASK, VZRO_VAL);
    assign hit_sreg = pat_hit(insn_i, SREG_MASK, SREG_VAL);
    assign hit_szro = pat_hit(insn_i, SZRO_MASK, SZRO_VAL);
    assign hit_o    = {hit_szro, hit_sreg, hit_vzro, hit_vreg};

    assign is_vec   = hit_vreg | hit_vzro;
    assign size_f   = insn_i[SIZE_LO +: 2];
    assign reserved = is_vec && (size_f == 2'b11) && !insn_i[FULL_BIT];

    always_comb begin
        op_o          = '0;
        op_o.form     = FORM_NONE;
        op_o.lw       = LW_64;
        op_o.rd       = insn_i[RD_LO +: IDX_W];
        op_o.rn       = insn_i[RN_LO +: IDX_W];
        unique case (1'b1)
            hit_vreg: begin
                op_o.form = FORM_VEC_REG;
                op_o.lw   = lane_w_e'(size_f);
                op_o.full = insn_i[FULL_BIT];
                op_o.rm   = insn_i[RM_LO +: IDX_W];
            end
            hit_vzro: begin
                op_o.form     = FORM_VEC_ZERO;
                op_o.lw       = lane_w_e'(size_f);
                op_o.full     = insn_i[FULL_BIT];
                op_o.use_zero = 1'b1;
            end
            hit_sreg: begin
                op_o.form = FORM_SCL_REG;
                op_o.rm   = insn_i[RM_LO +: IDX_W];
            end
            hit_szro: begin
                op_o.form     = FORM_SCL_ZERO;
                op_o.use_zero = 1'b1;
            end
            default: op_o.form = FORM_NONE;
        endcase
        op_o.legal = (op_o.form != FORM_NONE) && !reserved;
    end

endmodule

// File: rtl/sgt_lane_slice.sv
module sgt_lane_slice #(
    parameter int EW = 8
) (
    input  logic [EW-1:0] a_i,
    input  logic [EW-1:0] b_i,
    output logic [EW-1:0] mask_o
);

    logic gt;

    assign gt     = $signed(a_i) > $signed(b_i);
    assign mask_o = {EW{gt}};

endmodule

// File: rtl/sgt_lane_array.sv
module sgt_lane_array
    import simd_sgt_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  lane_w_e       lw_i,
    output logic [DW-1:0] mask_o
);

    logic [NUM_LW-1:0][DW-1:0] by_w;

    for (genvar w = 0; w < NUM_LW; w++) begin : g_width
        localparam int EW = MIN_LANE_W << w;
        localparam int NL = DW / EW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            sgt_lane_slice #(.EW(EW)) u_slice (
                .a_i    (a_i[l*EW +: EW]),
                .b_i    (b_i[l*EW +: EW]),
                .mask_o (by_w[w][l*EW +: EW])
            );
        end
    end

    assign mask_o = by_w[lw_i];

endmodule

// File: rtl/simd_sgt_cmp.sv
module simd_sgt_cmp
    import simd_sgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [INSN_W-1:0] insn_i,
    input  logic              insn_vld_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [IDX_W-1:0]  rd_o,
    output logic [IDX_W-1:0]  rn_o,
    output logic [IDX_W-1:0]  rm_o,
    output logic              res_vld_o,
    output logic              illegal_o
);

    dec_op_t              dec;
    logic [NUM_FORMS-1:0] hits;
    logic [DATA_W-1:0]    b_eff;
    logic [DATA_W-1:0]    raw_mask;
    logic [DATA_W-1:0]    shaped_mask;
    logic                 accept;
    res_t                 nxt, cur;

    sgt_decode u_dec (
        .insn_i (insn_i),
        .op_o   (dec),
        .hit_o  (hits)
    );

    assign b_eff = dec.use_zero ? '0 : opb_i;

    sgt_lane_array #(.DW(DATA_W)) u_lanes (
        .a_i    (opa_i),
        .b_i    (b_eff),
        .lw_i   (dec.lw),
        .mask_o (raw_mask)
    );

    assign shaped_mask = dec.full ? raw_mask : narrow_half(raw_mask);
    assign accept      = insn_vld_i && dec.legal;

    always_comb begin
        nxt     = '0;
        nxt.vld = accept;
        nxt.ill = insn_vld_i && !dec.legal;
        if (accept) begin
            nxt.mask = shaped_mask;
            nxt.rd   = dec.rd;
            nxt.rn   = dec.rn;
            nxt.rm   = dec.rm;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign mask_o    = cur.mask;
    assign rd_o      = cur.rd;
    assign rn_o      = cur.rn;
    assign rm_o      = cur.rm;
    assign res_vld_o = cur.vld;
    assign illegal_o = cur.ill;

    AST_ONE_FORM: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hits)); // R4
    AST_NO_BOTH_STROBES: assert property (@(posedge clk) disable iff (rst)
        !(res_vld_o && illegal_o)); // R10
    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        insn_vld_i |=> (res_vld_o || illegal_o)); // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !insn_vld_i |=> !(res_vld_o || illegal_o)); // R10
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !res_vld_o |-> (mask_o == '0 && rd_o == '0 && rn_o == '0 && rm_o == '0)); // R10
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (insn_vld_i && !dec.full) |=> (mask_o[DATA_W-1:HALF_W] == '0)); // R3
    AST_ZERO_FORM_RM: assert property (@(posedge clk) disable iff (rst)
        (insn_vld_i && dec.use_zero) |=> (rm_o == '0)); // R5
    AST_RESERVED_ILL: assert property (@(posedge clk) disable iff (rst)
        (insn_vld_i && (hits[0] || hits[1]) && insn_i[SIZE_LO +: 2] == 2'b11
         && !insn_i[FULL_BIT]) |=> (illegal_o && !res_vld_o)); // R8
    AST_UNMATCHED_ILL: assert property (@(posedge clk) disable iff (rst)
        (insn_vld_i && hits == '0) |=> illegal_o); // R9

endmodule

// File: tb/simd_sgt_cmp_tb.sv
`timescale 1ns/1ps
module simd_sgt_cmp_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [31:0]  insn = '0;
    logic         vld = 1'b0;
    logic [127:0] opa = '0, opb = '0;
    logic [127:0] mask;
    logic [4:0]   rd, rn, rm;
    logic         rvld, ill;

    int checks = 0, fails = 0;

    logic         have_exp = 1'b0;
    logic         e_vld, e_ill;
    logic [127:0] e_mask;
    logic [4:0]   e_rd, e_rn, e_rm;
    string        e_tag;

    always #4 clk = ~clk;

    simd_sgt_cmp u_dut (
        .clk(clk), .rst(rst), .insn_i(insn), .insn_vld_i(vld),
        .opa_i(opa), .opb_i(opb), .mask_o(mask), .rd_o(rd), .rn_o(rn),
        .rm_o(rm), .res_vld_o(rvld), .illegal_o(ill)
    );

    // 0 none, 1 vector reg, 2 vector zero, 3 scalar reg, 4 scalar zero
    function automatic int ref_kind(input logic [31:0] w);
        if (w ==? 32'b0?001110_??1?????_001101??_????????) return 1;
        if (w ==? 32'b0?001110_??100000_100010??_????????) return 2;
        if (w ==? 32'b01011110_111?????_001101??_????????) return 3;
        if (w ==? 32'b01011110_11100000_100010??_????????) return 4;
        return 0;
    endfunction

    function automatic logic ref_reserved(input logic [31:0] w);
        int k = ref_kind(w);
        return (k == 1 || k == 2) && w[23:22] == 2'b11 && !w[30];
    endfunction

    function automatic logic [127:0] ref_mask(input logic [31:0] w,
                                              input logic [127:0] a,
                                              input logic [127:0] b);
        int k = ref_kind(w);
        int esz, lim, sh;
        logic [127:0] r = '0;
        logic signed [63:0] sa, sb;
        logic [63:0] xa, xb;
        if (k == 1 || k == 2) begin
            esz = 8 << w[23:22];
            lim = w[30] ? 128 : 64;
        end else begin
            esz = 64;
            lim = 64;
        end
        sh = 64 - esz;
        for (int e = 0; e < 16; e++) begin
            if (e * esz < lim) begin
                xa = 64'(a >> (e * esz));
                xb = (k == 2 || k == 4) ? 64'd0 : 64'(b >> (e * esz));
                sa = $signed(xa << sh) >>> sh;
                sb = $signed(xb << sh) >>> sh;
                if (sa > sb)
                    for (int t = 0; t < esz; t++) r[e * esz + t] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic check_now();
        checks++;
        if (rvld !== e_vld || ill !== e_ill || mask !== e_mask ||
            rd !== e_rd || rn !== e_rn || rm !== e_rm) begin
            fails++;
            $display("FAIL %s: got vld=%b ill=%b rd=%0d rn=%0d rm=%0d mask=%h exp vld=%b ill=%b rd=%0d rn=%0d rm=%0d mask=%h",
                     e_tag, rvld, ill, rd, rn, rm, mask,
                     e_vld, e_ill, e_rd, e_rn, e_rm, e_mask);
        end
    endtask

    task automatic step(input logic [31:0] w, input logic [127:0] a,
                        input logic [127:0] b, input logic v, input string tag);
        int k;
        logic legal;
        @(negedge clk);
        if (have_exp) check_now();
        insn = w; opa = a; opb = b; vld = v;
        k = ref_kind(w);
        legal = (k != 0) && !ref_reserved(w);
        e_vld  = v && legal;
        e_ill  = v && !legal;
        e_mask = e_vld ? ref_mask(w, a, b) : '0;
        e_rd   = e_vld ? w[4:0] : '0;
        e_rn   = e_vld ? w[9:5] : '0;
        e_rm   = (e_vld && (k == 1 || k == 3)) ? w[20:16] : '0;
        if (tag != "") e_tag = tag;
        else if (!v) e_tag = "R10";
        else if (k == 0) e_tag = "R9";
        else if (ref_reserved(w)) e_tag = "R8";
        else if (k == 1) e_tag = "R4";
        else if (k == 2) e_tag = "R5";
        else if (k == 3) e_tag = "R6";
        else e_tag = "R7";
        have_exp = 1'b1;
    endtask

    function automatic logic [31:0] mk(input int form, input logic q,
                                       input logic [1:0] sz, input logic [4:0] m,
                                       input logic [4:0] n, input logic [4:0] d);
        case (form)
            1: return {1'b0, q, 1'b0, 5'b01110, sz, 1'b1, m, 6'b001101, n, d};
            2: return {1'b0, q, 1'b0, 5'b01110, sz, 9'b100000100, 1'b0, 2'b10, n, d};
            3: return {8'h5E, 3'b111, m, 6'b001101, n, d};
            default: return {8'h5E, 2'b11, 9'b100000100, 1'b0, 2'b10, n, d};
        endcase
    endfunction

    // every lane of width 8<<sz set to v (sign-truncated)
    function automatic logic [127:0] fill(input logic [1:0] sz, input logic [63:0] v);
        int esz = 8 << sz;
        logic [127:0] r = '0;
        for (int e = 0; e < 128 / esz; e++)
            for (int t = 0; t < esz; t++) r[e * esz + t] = v[t];
        return r;
    endfunction

    function automatic logic [63:0] pick_val(input int esz);
        logic [63:0] mn = 64'd1 << (esz - 1);
        case ($urandom % 7)
            0: return mn;
            1: return mn - 64'd1;
            2: return 64'd0;
            3: return '1;
            4: return 64'd1;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    function automatic logic [127:0] gen_vec(input logic [1:0] sz);
        int esz = 8 << sz;
        logic [127:0] r = '0;
        logic [63:0] v;
        for (int e = 0; e < 128 / esz; e++) begin
            v = pick_val(esz);
            for (int t = 0; t < esz; t++) r[e * esz + t] = v[t];
        end
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got no finish exp finish within limit");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [127:0] a, b, mn, mx;
        logic [31:0] w;
        void'($urandom(32'd20240611));

        // R12: reset holds outputs at zero even with a legal word presented
        insn = mk(1, 1'b1, 2'b00, 5'd3, 5'd4, 5'd5);
        vld = 1'b1; opa = fill(2'b00, 64'h7F); opb = '0;
        repeat (3) @(negedge clk);
        e_vld = 0; e_ill = 0; e_mask = '0; e_rd = 0; e_rn = 0; e_rm = 0;
        e_tag = "R12";
        check_now();
        vld = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_now(); // R12: first cycle after release

        // R1 / R2: extremes at every width, both directions and equal
        for (int s = 0; s < 4; s++) begin
            mn = fill(2'(s), 64'd1 << ((8 << s) - 1));
            mx = fill(2'(s), (64'd1 << ((8 << s) - 1)) - 64'd1);
            step(mk(1, 1'b1, 2'(s), 5'd1, 5'd2, 5'd3), mx, mn, 1'b1, "R1");
            step(mk(1, 1'b1, 2'(s), 5'd1, 5'd2, 5'd3), mn, mx, 1'b1, "R1");
            step(mk(1, 1'b1, 2'(s), 5'd1, 5'd2, 5'd3), mx, mx, 1'b1, "R1");
            step(mk(1, 1'b1, 2'(s), 5'd1, 5'd2, 5'd3), fill(2'(s), '1),
                 fill(2'(s), 64'd0), 1'b1, "R1");
            step(mk(1, 1'b1, 2'(s), 5'd9, 5'd8, 5'd7), gen_vec(2'(s)),
                 gen_vec(2'(s)), 1'b1, "R2");
        end

        // R3: narrow vector with full-width data
        a = fill(2'b00, 64'h05); b = '0;
        step(mk(1, 1'b0, 2'b00, 5'd1, 5'd1, 5'd1), a, b, 1'b1, "R3");
        step(mk(1, 1'b0, 2'b10, 5'd1, 5'd1, 5'd1), fill(2'b10, 64'h1), b, 1'b1, "R3");

        // R5 / R7: zero forms ignore the second operand
        a = fill(2'b01, 64'hFFFF);
        a[15:0] = 16'h0001; a[79:64] = 16'h8000; a[95:80] = 16'h7FFF;
        step(mk(2, 1'b1, 2'b01, 5'd0, 5'd6, 5'd2), a, '0, 1'b1, "R5");
        step(mk(2, 1'b1, 2'b01, 5'd0, 5'd6, 5'd2), a, '1, 1'b1, "R5");
        step(mk(4, 1'b0, 2'b00, 5'd0, 5'd11, 5'd12), {64'h1, 64'h1}, '1, 1'b1, "R7");
        step(mk(4, 1'b0, 2'b00, 5'd0, 5'd11, 5'd12), {64'h1, 64'h8000_0000_0000_0000},
             '0, 1'b1, "R7");

        // R6: scalar compares one 64-bit element, upper half zero
        step(mk(3, 1'b0, 2'b00, 5'd17, 5'd18, 5'd19),
             {64'h0, 64'h7FFF_FFFF_FFFF_FFFF}, {64'hF, 64'h8000_0000_0000_0000}, 1'b1, "R6");
        step(mk(3, 1'b0, 2'b00, 5'd17, 5'd18, 5'd19),
             {64'h7, 64'h0}, {64'h0, 64'h0}, 1'b1, "R6");

        // R8 / R9 interleaved with legal words, back to back
        step(mk(1, 1'b0, 2'b11, 5'd1, 5'd2, 5'd3), '1, '0, 1'b1, "R8");
        step(mk(1, 1'b1, 2'b11, 5'd1, 5'd2, 5'd3), {64'h1, 64'h0}, '0, 1'b1, "R2");
        step(mk(2, 1'b0, 2'b11, 5'd1, 5'd2, 5'd3), '1, '0, 1'b1, "R8");
        step(32'h0000_0000, '1, '0, 1'b1, "R9");
        step(32'h0E20_3401 ^ 32'h0000_0400, '1, '0, 1'b1, "R9");
        step(mk(1, 1'b1, 2'b00, 5'd31, 5'd30, 5'd29), '1, '0, 1'b1, "R11");
        step(32'hFFFF_FFFF, '1, '0, 1'b0, "R10");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int f = $urandom % 6;
            logic [1:0] sz = 2'($urandom);
            if (f == 5) w = $urandom;
            else w = mk((f == 0) ? 1 : f, 1'($urandom), sz, 5'($urandom),
                        5'($urandom), 5'($urandom));
            if (f >= 3 && f <= 4) sz = 2'b11;
            a = gen_vec(sz);
            b = ($urandom % 4 == 0) ? a : gen_vec(sz);
            step(w, a, b, ($urandom % 8) != 0, "");
        end

        step('0, '0, '0, 1'b0, "R10");
        @(negedge clk);
        check_now();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule